// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flag Controller

This block sits beside a 16-bit, 8K-word dual-port memory and turns its two highest words into mailboxes. It samples each port's chip enable, output enable, write strobe, address and the busy line coming from an external arbiter. A write from one port into the other port's mailbox word raises an interrupt toward that other port. The receiving port drops its interrupt by reading its own mailbox word.

The mailbox words stay ordinary storage holding a free-form 16-bit message. The block has no data path and never touches memory content; it only observes the control and address pins. The memory array and the arbiter are outside the block. All port controls and both interrupt outputs are active low, and the flags are registered on the block clock.

A parameter removes the interrupt function. In that case the two top words behave as plain memory and both interrupt lines stay inactive.

Top module: `mailbox_irq_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `l_int_n` and `r_int_n` become 1 (inactive) after that edge.
- R2: When the right port has `r_ce_n`=0, `r_we_n`=0, `r_busy_n`=1 and `r_addr`=0x1FFE at a rising edge, `l_int_n` is 0 after that edge.
- R3: When the left port has `l_ce_n`=0, `l_we_n`=0, `l_busy_n`=1 and `l_addr`=0x1FFF at a rising edge, `r_int_n` is 0 after that edge.
- R4: When the left port has `l_ce_n`=0, `l_oe_n`=0, `l_busy_n`=1 and `l_addr`=0x1FFE at a rising edge, and no R2 set occurs, `l_int_n` is 1 after that edge, whatever the value of `l_we_n`.
- R5: When the right port has `r_ce_n`=0, `r_oe_n`=0, `r_busy_n`=1 and `r_addr`=0x1FFF at a rising edge, and no R3 set occurs, `r_int_n` is 1 after that edge, whatever the value of `r_we_n`.
- R6: An access made while the acting port's busy input is 0 neither sets nor clears any interrupt flag.
- R7: Accesses to any other address, or with the needed enables inactive, leave both flags unchanged. A port writing its own mailbox does not set its own flag. A port reading the peer's mailbox does not clear the peer's flag.
- R8: If a set and a clear of the same flag fall on the same edge, the flag ends up active (0).
- R9: With `IRQ_EN`=0, both interrupt outputs stay 1 under every input pattern.
- R10: With no set and no clear of a flag on an edge, that flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_busy_n | input | 1 | Left busy from arbiter, active low |
| l_addr | input | ADDR_W | Left word address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_busy_n | input | 1 | Right busy from arbiter, active low |
| r_addr | input | ADDR_W | Right word address |
| l_int_n | output | 1 | Interrupt toward left port, active low |
| r_int_n | output | 1 | Interrupt toward right port, active low |

## Verification
The bench sweeps every combination of the four control bits on both ports, three address choices per port (each mailbox and one plain word) and all four starting flag states. The sweep exposes a design that swaps the mailbox addresses, that lets a port set its own flag, or that requires the write strobe to be high for a clear. It also exposes a design that ignores busy, or that lets a clear beat a simultaneous set, because each of these mispredicts at least one flag. A second instance built with the interrupts disabled catches outputs that leave the inactive level.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Decoded view of one port's control pins for a single clock
    typedef struct packed {
        logic wr;     // selected and write strobe active
        logic rd;     // selected and output enable active
        logic free;   // not blocked by the arbiter
    } port_cmd_t;

    function automatic port_cmd_t decode_cmd(input logic ce_n, input logic oe_n,
                                             input logic we_n, input logic busy_n);
        port_cmd_t c;
        c.wr   = !ce_n && !we_n;
        c.rd   = !ce_n && !oe_n;
        c.free = busy_n;
        return c;
    endfunction

    // Mailbox words are the two highest addresses of the array
    function automatic int unsigned mbx_left_word(input int unsigned aw);
        return (32'd1 << aw) - 32'd2;
    endfunction

    function automatic int unsigned mbx_right_word(input int unsigned aw);
        return (32'd1 << aw) - 32'd1;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = 13,
    parameter int unsigned OWN_WORD  = 8190,
    parameter int unsigned PEER_WORD = 8191
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              set_peer,
    output logic              clr_own
);
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_WORD);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_WORD);

    port_cmd_t cmd;

    always_comb begin
        cmd      = decode_cmd(ce_n, oe_n, we_n, busy_n);
        set_peer = cmd.free && cmd.wr && (addr == PEER_A);
        clr_own  = cmd.free && cmd.rd && (addr == OWN_A);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag_n
);
    logic active;

    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else if (set)
            active <= 1'b1;   // set has priority over clear
        else if (clr)
            active <= 1'b0;
    end

    assign flag_n = ~active;
endmodule

// File: rtl/mailbox_irq_ctrl.sv
module mailbox_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter bit          IRQ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic              l_busy_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic              r_busy_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_int_n,
    output logic              r_int_n
);
    localparam int unsigned L_WORD = mbx_left_word(ADDR_W);
    localparam int unsigned R_WORD = mbx_right_word(ADDR_W);

    logic l_sets_r, l_clrs_l;
    logic r_sets_l, r_clrs_r;

    mbx_port_decode #(
        .ADDR_W(ADDR_W), .OWN_WORD(L_WORD), .PEER_WORD(R_WORD)
    ) u_dec_l (
        .ce_n(l_ce_n), .oe_n(l_oe_n), .we_n(l_we_n), .busy_n(l_busy_n),
        .addr(l_addr), .set_peer(l_sets_r), .clr_own(l_clrs_l)
    );

    mbx_port_decode #(
        .ADDR_W(ADDR_W), .OWN_WORD(R_WORD), .PEER_WORD(L_WORD)
    ) u_dec_r (
        .ce_n(r_ce_n), .oe_n(r_oe_n), .we_n(r_we_n), .busy_n(r_busy_n),
        .addr(r_addr), .set_peer(r_sets_l), .clr_own(r_clrs_r)
    );

    generate
        if (IRQ_EN) begin : g_irq
            mbx_flag u_flag_l (
                .clk(clk), .rst(rst), .set(r_sets_l), .clr(l_clrs_l), .flag_n(l_int_n)
            );
            mbx_flag u_flag_r (
                .clk(clk), .rst(rst), .set(l_sets_r), .clr(r_clrs_r), .flag_n(r_int_n)
            );
        end else begin : g_no_irq
            assign l_int_n = 1'b1;
            assign r_int_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int unsigned ADDR_W = 13,
    parameter bit          IRQ_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              l_ce_n,
    input logic              l_oe_n,
    input logic              l_we_n,
    input logic              l_busy_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_ce_n,
    input logic              r_oe_n,
    input logic              r_we_n,
    input logic              r_busy_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_int_n,
    input logic              r_int_n
);
    localparam logic [ADDR_W-1:0] A_L = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] A_R = {ADDR_W{1'b1}};

    logic set_l, set_r, clr_l, clr_r;
    assign set_l = !r_ce_n && !r_we_n && r_busy_n && (r_addr == A_L);
    assign set_r = !l_ce_n && !l_we_n && l_busy_n && (l_addr == A_R);
    assign clr_l = !l_ce_n && !l_oe_n && l_busy_n && (l_addr == A_L);
    assign clr_r = !r_ce_n && !r_oe_n && r_busy_n && (r_addr == A_R);

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (l_int_n && r_int_n));

    generate
        if (IRQ_EN) begin : g_on
            p_set_left_r2: assert property (@(posedge clk) disable iff (rst)
                set_l |=> !l_int_n);
            p_set_right_r3: assert property (@(posedge clk) disable iff (rst)
                set_r |=> !r_int_n);
            p_clr_left_r4: assert property (@(posedge clk) disable iff (rst)
                (clr_l && !set_l) |=> l_int_n);
            p_clr_right_r5: assert property (@(posedge clk) disable iff (rst)
                (clr_r && !set_r) |=> r_int_n);
            p_hold_left_r10: assert property (@(posedge clk) disable iff (rst)
                (!set_l && !clr_l) |=> $stable(l_int_n));
            p_hold_right_r10: assert property (@(posedge clk) disable iff (rst)
                (!set_r && !clr_r) |=> $stable(r_int_n));
        end else begin : g_off
            p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
                (l_int_n && r_int_n));
        end
    endgenerate
endmodule

bind mailbox_irq_ctrl mbx_irq_chk #(.ADDR_W(ADDR_W), .IRQ_EN(IRQ_EN)) u_chk (.*);

// File: tb/mailbox_irq_ctrl_bench.sv
module mailbox_irq_ctrl_bench;
    localparam int AW = 13;
    localparam logic [AW-1:0] A_L = 13'h1FFE;
    localparam logic [AW-1:0] A_R = 13'h1FFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_ce_n = 1, l_oe_n = 1, l_we_n = 1, l_busy_n = 1;
    logic r_ce_n = 1, r_oe_n = 1, r_we_n = 1, r_busy_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_int_n, r_int_n, l_off_n, r_off_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    mailbox_irq_ctrl #(.ADDR_W(AW), .IRQ_EN(1'b1)) u_mailbox_irq_ctrl (
        .clk, .rst, .l_ce_n, .l_oe_n, .l_we_n, .l_busy_n, .l_addr,
        .r_ce_n, .r_oe_n, .r_we_n, .r_busy_n, .r_addr, .l_int_n, .r_int_n
    );

    mailbox_irq_ctrl #(.ADDR_W(AW), .IRQ_EN(1'b0)) u_off (
        .clk, .rst, .l_ce_n, .l_oe_n, .l_we_n, .l_busy_n, .l_addr,
        .r_ce_n, .r_oe_n, .r_we_n, .r_busy_n, .r_addr,
        .l_int_n(l_off_n), .r_int_n(r_off_n)
    );

    function automatic logic [AW-1:0] pick_addr(input int sel);
        return (sel == 0) ? A_L : (sel == 1) ? A_R : 13'h0123;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle();
        l_ce_n = 1; l_oe_n = 1; l_we_n = 1; l_busy_n = 1;
        r_ce_n = 1; r_oe_n = 1; r_we_n = 1; r_busy_n = 1;
        l_addr = '0; r_addr = '0;
    endtask

    // tag naming the rule that decides a flag's next value
    function automatic string tag(input bit set, input bit clr, input bit blocked,
                                  input bit is_left);
        if (set && clr) return "R8";
        if (set)        return is_left ? "R2" : "R3";
        if (clr)        return is_left ? "R4" : "R5";
        if (blocked)    return "R6";
        return "R7/R10";
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        idle();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        check("R1", l_int_n, 1'b1);
        check("R1", r_int_n, 1'b1);

        for (int init = 0; init < 4; init++)
        for (int lc = 0; lc < 16; lc++)
        for (int la = 0; la < 3; la++)
        for (int rc = 0; rc < 16; rc++)
        for (int ra = 0; ra < 3; ra++) begin
            bit il, ir, lce, loe, lwe, lbz, rce, roe, rwe, rbz;
            bit set_l, set_r, clr_l, clr_r, blk_l, blk_r;
            logic exp_l, exp_r;
            // control bit order: [0]=ce_n [1]=oe_n [2]=we_n [3]=busy_n
            il  = init[0];  ir = init[1];
            lce = !lc[0]; loe = !lc[1]; lwe = !lc[2]; lbz = !lc[3];
            rce = !rc[0]; roe = !rc[1]; rwe = !rc[2]; rbz = !rc[3];

            @(negedge clk);
            rst = 1; idle();
            @(negedge clk);
            rst = 0;
            if (il) begin r_ce_n = 0; r_we_n = 0; r_addr = A_L; end
            if (ir) begin l_ce_n = 0; l_we_n = 0; l_addr = A_R; end
            @(negedge clk);
            l_ce_n = lc[0]; l_oe_n = lc[1]; l_we_n = lc[2]; l_busy_n = lc[3];
            r_ce_n = rc[0]; r_oe_n = rc[1]; r_we_n = rc[2]; r_busy_n = rc[3];
            l_addr = pick_addr(la); r_addr = pick_addr(ra);
            @(negedge clk);
            idle();

            set_l = rce && rwe && !rbz && (ra == 0);
            set_r = lce && lwe && !lbz && (la == 1);
            clr_l = lce && loe && !lbz && (la == 0);
            clr_r = rce && roe && !rbz && (ra == 1);
            blk_l = (rbz && rce && rwe && ra == 0) || (lbz && lce && loe && la == 0);
            blk_r = (lbz && lce && lwe && la == 1) || (rbz && rce && roe && ra == 1);
            exp_l = set_l ? 1'b0 : clr_l ? 1'b1 : !il;
            exp_r = set_r ? 1'b0 : clr_r ? 1'b1 : !ir;

            check(tag(set_l, clr_l, blk_l, 1'b1), l_int_n, exp_l);
            check(tag(set_r, clr_r, blk_r, 1'b0), r_int_n, exp_r);
            check("R9", l_off_n, 1'b1);
            check("R9", r_off_n, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule